// File: doc/BRIEF.md
# Run-Pattern Huffman Test Decompressor

This block sits between a tester and a scan chain and expands a compressed test stream back into scan data. The tester delivers one compressed bit per tester clock over a valid/ready stream. A decoding state machine in the tester clock domain walks a small prefix-free code tree. Each finished codeword names one of five run patterns. A pattern of index k below 4 is k zero bits followed by a single one bit. Pattern 4 is four zero bits with no closing one, so the run continues into the next codeword.

A generation unit on the faster on-chip test clock shifts the chosen pattern out on a serial data line. It raises a scan clock enable for exactly one test clock per emitted bit. The pattern index crosses between the clock domains through a toggle request and a toggle acknowledge, each passed through a two-flop synchronizer. The stream's ready line is the back-pressure to the tester. It drops as soon as a codeword is complete and stays low until the acknowledge returns, so the tester holds its next bit, with valid high, for as long as it needs to. A bit transfers only on a tester clock edge where valid and ready are both high. Holding valid low inserts idle cycles at any point, including the middle of a codeword.

Top module: `vrun_decomp`

## Requirements
- R1: While either reset is high and in the first cycle after it, `cbit_ready` is 1 and `scan_clk_en` and `scan_data` are 0.
- R2: The one-bit codeword "1" produces four output bits, all 0.
- R3: The codeword "000" produces a single output bit of value 1.
- R4: The codewords "001", "010" and "011" produce "01", "001" and "0001" respectively (bits listed in order of transmission, first bit first).
- R5: A compressed bit is consumed only on a tester clock edge where `cbit_valid` and `cbit_ready` are both 1; idle cycles with valid low, inside or between codewords, leave the decoded output unchanged.
- R6: `cbit_ready` is 0 in the tester cycle after the last bit of a codeword is accepted, stays 0 until that pattern has been shifted out, and then returns to 1; a bit held on the input during that time is consumed once, afterwards.
- R7: `scan_clk_en` is high for exactly one test clock per pattern bit, and `scan_data` is 1 only on the final bit of patterns 0 to 3.
- R8: A reset in the middle of a codeword returns the decoder to the root of the code tree, discarding the bits taken so far.
- R9: For any sequence of codewords, the concatenated scan output equals the concatenation of the patterns they name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ate_clk | input | 1 | Tester clock, one compressed bit per cycle |
| ate_rst | input | 1 | Synchronous active-high reset, tester domain |
| cbit_valid | input | 1 | Compressed bit on `cbit_data` is valid |
| cbit_data | input | 1 | Compressed bit |
| cbit_ready | output | 1 | Decoder can take a bit; low while a pattern is being generated |
| tck | input | 1 | On-chip test clock, faster than `ate_clk` |
| tck_rst | input | 1 | Synchronous active-high reset, test clock domain |
| scan_data | output | 1 | Serial scan data |
| scan_clk_en | output | 1 | One-cycle-per-bit enable for the scan clock gate |

## Verification
The assertions take for granted that both resets are applied together for several cycles of the slower clock, and that the test clock runs fast enough for the two-flop synchronizers to sample every toggle. They also rely on the tester keeping `cbit_data` steady while it holds valid high against a low ready. The bench drives both resets in the same tester cycles. It runs the test clock four times faster than the tester clock, and it changes input data only on tester clock falling edges after a transfer, or while valid is low.

// File: rtl/vrun_pkg.sv
package vrun_pkg;
  // run length cap; the code tree below is built for this value
  localparam int GROUP_M = 4;
  localparam int IDX_W   = $clog2(GROUP_M + 1);
  localparam int CNT_W   = $clog2(GROUP_M + 2);
  localparam logic [IDX_W-1:0] IDX_RUN = IDX_W'(GROUP_M);

  typedef enum logic [1:0] {ND_ROOT, ND_0, ND_00, ND_01} node_e;

  // number of bits a pattern expands to
  function automatic logic [CNT_W-1:0] pat_len(input logic [IDX_W-1:0] idx);
    if (idx == IDX_RUN) return CNT_W'(GROUP_M);
    return CNT_W'(idx) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/vrun_sync.sv
module vrun_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b0;
        else if (i == 0) sh[i] <= d;
        else sh[i] <= sh[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/vrun_huff_fsm.sv
module vrun_huff_fsm
  import vrun_pkg::*;
(
  input  logic             ate_clk,
  input  logic             ate_rst,
  input  logic             in_valid,
  input  logic             in_data,
  output logic             in_ready,
  input  logic             ack_sync,
  output logic             req_tgl,
  output logic [IDX_W-1:0] pat_idx
);
  node_e            node_q, node_d;
  logic             done;
  logic [IDX_W-1:0] idx_d;
  logic             take;

  assign in_ready = (req_tgl == ack_sync);
  assign take     = in_valid && in_ready;

  always_comb begin
    node_d = node_q;
    done   = 1'b0;
    idx_d  = '0;
    unique case (node_q)
      ND_ROOT: if (in_data) begin done = 1'b1; idx_d = IDX_RUN; end
               else node_d = ND_0;
      ND_0:    node_d = in_data ? ND_01 : ND_00;
      ND_00:   begin done = 1'b1; idx_d = in_data ? IDX_W'(1) : IDX_W'(0); end
      ND_01:   begin done = 1'b1; idx_d = in_data ? IDX_W'(3) : IDX_W'(2); end
      default: node_d = ND_ROOT;
    endcase
    if (done) node_d = ND_ROOT;
  end

  always_ff @(posedge ate_clk) begin
    if (ate_rst) begin
      node_q  <= ND_ROOT;
      req_tgl <= 1'b0;
      pat_idx <= '0;
    end else if (take) begin
      node_q <= node_d;
      if (done) begin
        pat_idx <= idx_d;
        req_tgl <= ~req_tgl;
      end
    end
  end

  // R6: a finished codeword stalls the tester on the next cycle
  a_r6_stall_after_code: assert property (@(posedge ate_clk) disable iff (ate_rst)
    (take && done) |=> !in_ready);

  // R6: the index handed to the other domain is held while busy
  a_r6_idx_hold: assert property (@(posedge ate_clk) disable iff (ate_rst)
    (!in_ready && $past(!in_ready)) |-> $stable(pat_idx));

  // R4: every issued request carries a legal pattern index
  a_r4_idx_range: assert property (@(posedge ate_clk) disable iff (ate_rst)
    (req_tgl != $past(req_tgl)) |-> (pat_idx <= IDX_RUN));
endmodule

// File: rtl/vrun_gen.sv
module vrun_gen
  import vrun_pkg::*;
(
  input  logic             tck,
  input  logic             tck_rst,
  input  logic             req_sync,
  input  logic [IDX_W-1:0] pat_idx,
  output logic             ack_tgl,
  output logic             scan_data,
  output logic             scan_clk_en
);
  logic             seen_q;
  logic             active_q;
  logic             term_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start;
  logic             last;

  assign start = !active_q && (req_sync != seen_q);
  assign last  = (cnt_q == CNT_W'(1));

  always_ff @(posedge tck) begin
    if (tck_rst) begin
      seen_q   <= 1'b0;
      active_q <= 1'b0;
      term_q   <= 1'b0;
      cnt_q    <= '0;
      ack_tgl  <= 1'b0;
    end else if (start) begin
      seen_q   <= req_sync;
      active_q <= 1'b1;
      cnt_q    <= pat_len(pat_idx);
      term_q   <= (pat_idx != IDX_RUN);
    end else if (active_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (last) begin
        active_q <= 1'b0;
        ack_tgl  <= seen_q;
      end
    end
  end

  assign scan_clk_en = active_q;
  assign scan_data   = active_q && term_q && last;

  // R7: a one bit always comes with a scan clock pulse
  a_r7_one_pulsed: assert property (@(posedge tck) disable iff (tck_rst)
    scan_data |-> scan_clk_en);

  // R7: the closing one is the last bit of its pattern
  a_r7_one_is_last: assert property (@(posedge tck) disable iff (tck_rst)
    scan_data |=> !scan_clk_en);

  // R7: the bit counter stays within one pattern length
  a_r7_cnt_range: assert property (@(posedge tck) disable iff (tck_rst)
    scan_clk_en |-> (cnt_q >= CNT_W'(1) && cnt_q <= CNT_W'(GROUP_M)));

  // R6: acknowledge only follows the end of a pattern
  a_r6_ack_at_end: assert property (@(posedge tck) disable iff (tck_rst)
    (ack_tgl != $past(ack_tgl)) |-> $past(scan_clk_en));
endmodule

// File: rtl/vrun_decomp.sv
module vrun_decomp
  import vrun_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic ate_clk,
  input  logic ate_rst,
  input  logic cbit_valid,
  input  logic cbit_data,
  output logic cbit_ready,
  input  logic tck,
  input  logic tck_rst,
  output logic scan_data,
  output logic scan_clk_en
);
  logic             req_tgl, req_sync;
  logic             ack_tgl, ack_sync;
  logic [IDX_W-1:0] pat_idx;

  vrun_huff_fsm u_fsm (
    .ate_clk (ate_clk),
    .ate_rst (ate_rst),
    .in_valid(cbit_valid),
    .in_data (cbit_data),
    .in_ready(cbit_ready),
    .ack_sync(ack_sync),
    .req_tgl (req_tgl),
    .pat_idx (pat_idx)
  );

  vrun_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(tck), .rst(tck_rst), .d(req_tgl), .q(req_sync)
  );

  vrun_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(ate_clk), .rst(ate_rst), .d(ack_tgl), .q(ack_sync)
  );

  vrun_gen u_gen (
    .tck        (tck),
    .tck_rst    (tck_rst),
    .req_sync   (req_sync),
    .pat_idx    (pat_idx),
    .ack_tgl    (ack_tgl),
    .scan_data  (scan_data),
    .scan_clk_en(scan_clk_en)
  );
endmodule

// File: tb/vrun_decomp_bench.sv
module vrun_decomp_bench;
  logic ate_clk = 1'b0;
  logic tck = 1'b0;
  logic ate_rst = 1'b1;
  logic tck_rst = 1'b1;
  logic cbit_valid = 1'b0;
  logic cbit_data = 1'b0;
  logic cbit_ready, scan_data, scan_clk_en;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic obs_q [0:1023];
  logic exp_q [0:1023];
  int obs_n = 0;
  int exp_n = 0;

  always #10 tck = ~tck;       // 50 MHz test clock
  always #40 ate_clk = ~ate_clk; // tester clock, four times slower

  vrun_decomp u_vrun_decomp (
    .ate_clk(ate_clk), .ate_rst(ate_rst), .cbit_valid(cbit_valid),
    .cbit_data(cbit_data), .cbit_ready(cbit_ready), .tck(tck),
    .tck_rst(tck_rst), .scan_data(scan_data), .scan_clk_en(scan_clk_en)
  );

  always @(negedge tck) begin
    if (!tck_rst && scan_clk_en) begin
      obs_q[obs_n] = scan_data;
      obs_n = obs_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_streams();
    obs_n = 0;
    exp_n = 0;
  endtask

  task automatic expect_pat(input int k);
    int n = (k == 4) ? 4 : k + 1;
    for (int i = 0; i < n; i++) begin
      exp_q[exp_n] = (k != 4) && (i == n - 1);
      exp_n++;
    end
  endtask

  // called at a tester falling edge, returns at a falling edge
  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      cbit_valid = 1'b0;
      cbit_data = ~cbit_data;
      @(negedge ate_clk);
    end
    cbit_valid = 1'b1;
    cbit_data = b;
    while (!cbit_ready) @(negedge ate_clk);
    @(negedge ate_clk);
    cbit_valid = 1'b0;
  endtask

  task automatic send_pat(input int k, input int gap);
    case (k)
      4: send_bit(1'b1, gap);
      0: begin send_bit(1'b0, gap); send_bit(1'b0, gap); send_bit(1'b0, gap); end
      1: begin send_bit(1'b0, gap); send_bit(1'b0, gap); send_bit(1'b1, gap); end
      2: begin send_bit(1'b0, gap); send_bit(1'b1, gap); send_bit(1'b0, gap); end
      default: begin send_bit(1'b0, gap); send_bit(1'b1, gap); send_bit(1'b1, gap); end
    endcase
    expect_pat(k);
  endtask

  task automatic wait_idle();
    while (!cbit_ready) @(negedge ate_clk);
    repeat (2) @(negedge ate_clk);
  endtask

  task automatic compare(input string req);
    int bad = -1;
    chk(obs_n == exp_n, {req, " length"}, obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++)
      if (bad < 0 && obs_q[i] !== exp_q[i]) bad = i;
    chk(bad < 0, {req, " bits"}, (bad < 0) ? 0 : int'(obs_q[bad]),
        (bad < 0) ? 0 : int'(exp_q[bad]));
  endtask

  task automatic do_reset();
    ate_rst = 1'b1;
    tck_rst = 1'b1;
    cbit_valid = 1'b0;
    repeat (3) @(negedge ate_clk);
    chk(cbit_ready === 1'b1, "R1 ready in reset", cbit_ready, 1);
    chk(scan_clk_en === 1'b0 && scan_data === 1'b0, "R1 outputs in reset",
        {scan_clk_en, scan_data}, 0);
    ate_rst = 1'b0;
    tck_rst = 1'b0;
    @(negedge ate_clk);
    chk(cbit_ready === 1'b1, "R1 ready after reset", cbit_ready, 1);
    chk(scan_clk_en === 1'b0, "R1 no pulse after reset", scan_clk_en, 0);
    clear_streams();
  endtask

  task automatic t_each_code();
    int k;
    string tag;
    for (int i = 0; i < 5; i++) begin
      k = (i + 4) % 5;
      clear_streams();
      send_pat(k, 0);
      wait_idle();
      tag = (k == 4) ? "R2" : (k == 0) ? "R3" : "R4";
      compare($sformatf("%s R7 pattern %0d", tag, k));
    end
  endtask

  task automatic t_gaps();
    clear_streams();
    send_pat(2, 3);
    send_pat(4, 2);
    send_pat(0, 1);
    wait_idle();
    compare("R5 idle gaps");
  endtask

  task automatic t_stall();
    clear_streams();
    send_bit(1'b0, 0);
    send_bit(1'b1, 0);
    send_bit(1'b1, 0);
    expect_pat(3);
    chk(cbit_ready === 1'b0, "R6 ready low after codeword", cbit_ready, 0);
    send_bit(1'b1, 0);
    expect_pat(4);
    wait_idle();
    chk(cbit_ready === 1'b1, "R6 ready returns", cbit_ready, 1);
    compare("R6 held bit consumed once");
  endtask

  task automatic t_reset_mid();
    send_bit(1'b0, 0);
    do_reset();
    send_pat(4, 0);
    wait_idle();
    compare("R8 reset mid codeword");
  endtask

  task automatic t_random();
    clear_streams();
    for (int i = 0; i < 80; i++) send_pat($urandom_range(0, 4), $urandom_range(0, 1));
    wait_idle();
    compare("R9 random stream");
  endtask

  initial begin
    do_reset();
    t_each_code();
    t_gaps();
    t_stall();
    t_reset_mid();
    t_random();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule